// File: doc/BRIEF.md
# Fine Phase-Shift Step Controller

This block holds the signed offset used to trim the phase of a clock, and changes it one unit at a time when a requester on a dedicated phase-control clock asks for it. The application of the offset to a delay line or an analog element happens elsewhere. This block only keeps the value and runs the request/acknowledge exchange with the requester.

A requester raises the enable for one control-clock cycle, with the direction input set to up or down. The controller then becomes busy. A fixed number of cycles later it applies the step and raises a one-cycle done pulse. The mode input has three settings. In the no-shift setting the value is forced to zero. In the fixed setting the value is loaded from a configuration input at reset and then held. In the variable setting steps are accepted. The value never leaves the range -255 to +255.

Top module: `phase_shift_stepper`

## Requirements
- R1: While `psRst` is high at a rising edge of `psClk`, `phaseVal` loads the clamped `fixedInit` if `modeSel` is 2'b01 (fixed), and loads zero otherwise. `stepDone` is 0 after reset.
- R2: In variable mode (`modeSel` = 2'b10), a rising edge that samples `stepEn` high with `stepUp` = 1 raises `phaseVal` by one. The new value appears together with `stepDone`, exactly `DONE_LAT` (default 3) edges after the sampling edge.
- R3: In variable mode, a sampled request with `stepUp` = 0 lowers `phaseVal` by one, with the same timing as R2.
- R4: `phaseVal` always stays within -255 to +255. A step that would leave this range leaves the value unchanged, and `stepDone` still pulses.
- R5: `stepDone` is high for exactly one `psClk` cycle per accepted request.
- R6: `stepEn` pulses sampled while a step is in progress are ignored. They produce no extra done pulse and no extra change of value.
- R7: In fixed mode (`modeSel` = 2'b01), `stepEn` has no effect. No done pulse follows and the value holds.
- R8: With `modeSel` = 2'b00 or 2'b11 (no shift), `phaseVal` becomes zero one edge later and stays zero. Requests are not acknowledged.
- R9: A `fixedInit` outside -255 to +255 is clamped to the nearest limit when it is loaded.
- R10: The direction of a step is taken from `stepUp` at the edge that accepts the request. Later changes of `stepUp` do not affect that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| psClk | input | 1 | Phase-control clock; all inputs are sampled on its rising edge |
| psRst | input | 1 | Synchronous reset, active high |
| modeSel | input | 2 | 00/11 no shift, 01 fixed, 10 variable |
| fixedInit | input | 10 | Signed initial offset used in fixed mode |
| stepEn | input | 1 | Step request |
| stepUp | input | 1 | 1 = increment, 0 = decrement |
| phaseVal | output | 10 | Current signed phase offset |
| stepDone | output | 1 | One-cycle acknowledge of a completed step |

## Verification
Two events can fall in the same cycle: the acknowledge of a step that hits the range limit, and the clamp that keeps the value in range. The bench provokes this by loading a value near a limit in fixed mode, switching to variable mode, and stepping past the limit. It then checks that the done pulse still arrives on its exact cycle while the value stays at the limit. A second overlap is a new request that arrives while a step is still busy. Here the bench holds the enable high through the busy window and checks that only one acknowledge and one unit of change follow.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;
  typedef enum logic [1:0] {
    PS_NONE  = 2'b00,
    PS_FIXED = 2'b01,
    PS_VAR   = 2'b10,
    PS_RSVD  = 2'b11
  } psMode_e;

  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } stepStrobe_t;
endpackage

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phase_step_pkg::*;
#(
  parameter int DONE_LAT = 3
) (
  input  logic        psClk,
  input  logic        psRst,
  input  logic        isVar,
  input  logic        stepEn,
  input  logic        stepUp,
  output stepStrobe_t stb,
  output logic        stepDone
);
  localparam int CNT_W = $clog2(DONE_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DONE_LAT);

  logic             busy;
  logic             dirUp;
  logic [CNT_W-1:0] cnt;
  logic             fire;

  assign fire = busy && (cnt == CNT_END);

  always_ff @(posedge psClk) begin
    if (psRst) begin
      busy     <= 1'b0;
      dirUp    <= 1'b0;
      cnt      <= '0;
      stepDone <= 1'b0;
    end else begin
      stepDone <= fire;
      if (fire) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
      end else if (stepEn && isVar) begin
        busy  <= 1'b1;
        cnt   <= CNT_W'(1);
        dirUp <= stepUp;
      end
    end
  end

  always_comb begin
    stb.load = psRst;
    stb.inc  = fire && dirUp;
    stb.dec  = fire && !dirUp;
  end

  // R5: acknowledge lasts a single cycle
  p_done_single_r5: assert property (@(posedge psClk) disable iff (psRst)
    stepDone |=> !stepDone);

  // R2: an acknowledge only follows a busy step
  p_done_after_busy_r2: assert property (@(posedge psClk) disable iff (psRst)
    $rose(stepDone) |-> $past(busy));

  // R6: a request during a busy step does not restart the count
  p_busy_ignore_r6: assert property (@(posedge psClk) disable iff (psRst)
    (busy && stepEn && !fire) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));

  // R10: the direction is frozen while busy
  p_dir_frozen_r10: assert property (@(posedge psClk) disable iff (psRst)
    (busy && !fire) |=> $stable(dirUp));
endmodule

// File: rtl/phase_value_dp.sv
module phase_value_dp
  import phase_step_pkg::*;
#(
  parameter int VAL_W     = 10,
  parameter int MAX_SHIFT = 255
) (
  input  logic                    psClk,
  input  stepStrobe_t             stb,
  input  logic                    isFixed,
  input  logic                    isNone,
  input  logic signed [VAL_W-1:0] fixedInit,
  output logic signed [VAL_W-1:0] phaseVal
);
  localparam logic signed [VAL_W-1:0] POS_LIM = VAL_W'(MAX_SHIFT);
  localparam logic signed [VAL_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [VAL_W-1:0] initClamped;

  always_comb begin
    if (fixedInit > POS_LIM)      initClamped = POS_LIM;
    else if (fixedInit < NEG_LIM) initClamped = NEG_LIM;
    else                          initClamped = fixedInit;
  end

  always_ff @(posedge psClk) begin
    if (stb.load) begin
      phaseVal <= isFixed ? initClamped : '0;
    end else if (isNone) begin
      phaseVal <= '0;
    end else if (stb.inc && (phaseVal < POS_LIM)) begin
      phaseVal <= phaseVal + VAL_W'(1);
    end else if (stb.dec && (phaseVal > NEG_LIM)) begin
      phaseVal <= phaseVal - VAL_W'(1);
    end
  end

  // R4: the value stays inside the allowed range
  p_range_r4: assert property (@(posedge psClk) disable iff (stb.load)
    (phaseVal <= POS_LIM) && (phaseVal >= NEG_LIM));

  // R4: a step at the upper limit does not wrap
  p_no_overflow_r4: assert property (@(posedge psClk) disable iff (stb.load)
    (stb.inc && !isNone && phaseVal == POS_LIM) |=> (phaseVal == POS_LIM));

  // R4: a step at the lower limit does not wrap
  p_no_underflow_r4: assert property (@(posedge psClk) disable iff (stb.load)
    (stb.dec && !isNone && phaseVal == NEG_LIM) |=> (phaseVal == NEG_LIM));

  // R8: no-shift mode forces zero
  p_none_zero_r8: assert property (@(posedge psClk) disable iff (stb.load)
    isNone |=> (phaseVal == '0));

  // R7: without a step strobe the value holds
  p_hold_r7: assert property (@(posedge psClk) disable iff (stb.load)
    (!stb.inc && !stb.dec && !isNone) |=> $stable(phaseVal));
endmodule

// File: rtl/phase_shift_stepper.sv
module phase_shift_stepper
  import phase_step_pkg::*;
#(
  parameter int VAL_W     = 10,
  parameter int MAX_SHIFT = 255,
  parameter int DONE_LAT  = 3
) (
  input  logic                    psClk,
  input  logic                    psRst,
  input  logic [1:0]              modeSel,
  input  logic signed [VAL_W-1:0] fixedInit,
  input  logic                    stepEn,
  input  logic                    stepUp,
  output logic signed [VAL_W-1:0] phaseVal,
  output logic                    stepDone
);
  psMode_e     mode;
  stepStrobe_t stb;
  logic        isVar, isFixed, isNone;

  assign mode    = psMode_e'(modeSel);
  assign isVar   = (mode == PS_VAR);
  assign isFixed = (mode == PS_FIXED);
  assign isNone  = (mode == PS_NONE) || (mode == PS_RSVD);

  phase_step_ctrl #(.DONE_LAT(DONE_LAT)) i_ctrl (
    .psClk    (psClk),
    .psRst    (psRst),
    .isVar    (isVar),
    .stepEn   (stepEn),
    .stepUp   (stepUp),
    .stb      (stb),
    .stepDone (stepDone)
  );

  phase_value_dp #(.VAL_W(VAL_W), .MAX_SHIFT(MAX_SHIFT)) i_dp (
    .psClk     (psClk),
    .stb       (stb),
    .isFixed   (isFixed),
    .isNone    (isNone),
    .fixedInit (fixedInit),
    .phaseVal  (phaseVal)
  );
endmodule

// File: tb/test_phase_shift_stepper.sv
module test_phase_shift_stepper;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int NVEC = 8;
  localparam bit VEC_UP  [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam int VEC_EXP [NVEC] = '{1, 2, 3, 2, 1, 0, -1, 0};

  logic              psClk = 1'b0;
  logic              psRst = 1'b1;
  logic [1:0]        modeSel = 2'b10;
  logic signed [9:0] fixedInit = '0;
  logic              stepEn = 1'b0;
  logic              stepUp = 1'b0;
  logic signed [9:0] phaseVal;
  logic              stepDone;

  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD / 2) psClk = ~psClk;

  phase_shift_stepper i_phase_shift_stepper (
    .psClk(psClk), .psRst(psRst), .modeSel(modeSel), .fixedInit(fixedInit),
    .stepEn(stepEn), .stepUp(stepUp), .phaseVal(phaseVal), .stepDone(stepDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] m, input int init);
    @(negedge psClk);
    psRst = 1'b1; modeSel = m; fixedInit = 10'(init); stepEn = 1'b0;
    @(negedge psClk);
    @(negedge psClk);
    psRst = 1'b0;
  endtask

  // one request; stepUp flipped after acceptance (R10)
  task automatic doStep(input bit up, input int exp, input string tag);
    @(negedge psClk);
    stepEn = 1'b1; stepUp = up;
    @(negedge psClk);
    stepEn = 1'b0; stepUp = ~up;
    check(stepDone == 1'b0, {tag, " early done"}, int'(stepDone), 0);
    for (int i = 1; i < LAT; i++) begin
      @(negedge psClk);
      check(stepDone == 1'b0, {tag, " early done"}, int'(stepDone), 0);
    end
    @(negedge psClk);
    check(stepDone == 1'b1, {tag, " done on time"}, int'(stepDone), 1);
    check(phaseVal == 10'(exp), {tag, " value"}, int'(phaseVal), exp);
    @(negedge psClk);
    check(stepDone == 1'b0, "R5 done one cycle", int'(stepDone), 0);
  endtask

  task automatic watchQuiet(input int n, input int exp, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge psClk);
      check(stepDone == 1'b0, {tag, " no done"}, int'(stepDone), 0);
    end
    check(phaseVal == 10'(exp), {tag, " value"}, int'(phaseVal), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    // R1: reset in variable mode
    doReset(2'b10, 77);
    @(negedge psClk);
    check(phaseVal == 0, "R1 reset value var", int'(phaseVal), 0);
    check(stepDone == 0, "R1 reset done", int'(stepDone), 0);

    // R2 R3 R10: vector table walk
    for (int v = 0; v < NVEC; v++)
      doStep(VEC_UP[v], VEC_EXP[v], VEC_UP[v] ? "R2 inc R10" : "R3 dec R10");

    // R6: enable held through busy window
    @(negedge psClk);
    stepEn = 1'b1; stepUp = 1'b1;
    @(negedge psClk);
    @(negedge psClk);
    @(negedge psClk);
    stepEn = 1'b0;
    @(negedge psClk);
    check(stepDone == 1'b1, "R6 single done", int'(stepDone), 1);
    check(phaseVal == 1, "R6 value", int'(phaseVal), 1);
    watchQuiet(6, 1, "R6 ignored");

    // R1 R9: fixed mode load and clamp
    doReset(2'b01, 123);
    @(negedge psClk);
    check(phaseVal == 123, "R1 fixed load", int'(phaseVal), 123);
    doReset(2'b01, 400);
    @(negedge psClk);
    check(phaseVal == 255, "R9 clamp high", int'(phaseVal), 255);
    doReset(2'b01, -400);
    @(negedge psClk);
    check(phaseVal == -255, "R9 clamp low", int'(phaseVal), -255);

    // R7: enable ignored in fixed mode
    doReset(2'b01, 42);
    @(negedge psClk);
    stepEn = 1'b1; stepUp = 1'b1;
    @(negedge psClk);
    stepEn = 1'b0;
    watchQuiet(LAT + 3, 42, "R7 fixed");

    // R4: upper limit
    doReset(2'b01, 253);
    modeSel = 2'b10;
    doStep(1'b1, 254, "R2 near top");
    doStep(1'b1, 255, "R2 top");
    doStep(1'b1, 255, "R4 sat high");

    // R4: lower limit
    doReset(2'b01, -254);
    modeSel = 2'b10;
    doStep(1'b0, -255, "R3 bottom");
    doStep(1'b0, -255, "R4 sat low");
    doStep(1'b1, -254, "R4 leave low");

    // R8: switching to no-shift zeroes value, requests unanswered
    @(negedge psClk);
    modeSel = 2'b00;
    @(negedge psClk);
    check(phaseVal == 0, "R8 zeroed", int'(phaseVal), 0);
    stepEn = 1'b1; stepUp = 1'b1;
    @(negedge psClk);
    stepEn = 1'b0;
    watchQuiet(LAT + 3, 0, "R8 none");
    modeSel = 2'b11;
    watchQuiet(3, 0, "R8 reserved");
    doReset(2'b00, 99);
    @(negedge psClk);
    check(phaseVal == 0, "R1 reset none", int'(phaseVal), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule